// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block turns parallel stereo sample pairs into a single serial data line. The bit clock and the left-right / frame-sync clock are supplied from outside and arrive as plain inputs that are sampled by the block's system clock. Every new data bit is driven when a falling bit-clock edge is detected, so a downstream receiver can take it on the following rising edge. Five framings are selectable: left justified, I2S and right justified (stereo, one word per clock phase) and two DSP variants (a frame-sync pulse followed by a left word and a right word back to back). Words always go out MSB first.

Samples are offered through a valid/ready handshake into a one-entry pending register. At each frame start the pending pair moves into the holding register that feeds the serializer, so a load in the middle of a frame never disturbs the word on the wire. If nothing is pending at a frame start, the previous pair is sent again and an underrun flag is raised.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `sdata` is 0, `underrun` is 0 and `in_ready` is 1.
- R2: Format code 0 (left justified): the MSB goes out on the same falling bit-clock edge at which `lrclk` changes; the phase with `lrclk` high carries the left word and the low phase carries the right word.
- R3: Format code 2 (I2S): the MSB goes out one bit clock after the `lrclk` change; `lrclk` low carries left and high carries right; each phase must last at least word length plus one bit clocks.
- R4: Format code 1 (right justified): the LSB is sent on the last bit clock before the next `lrclk` change, with the start of the word placed using the length of the previous phase of the same `lrclk` level; high carries left.
- R5: Format code 3 (DSP early): the left MSB is sent on the falling edge at which `lrclk` is first seen high, the right word follows immediately after the left LSB.
- R6: Format code 4 (DSP late): as R5 but everything is delayed by one bit clock.
- R7: In every format the line is 0 on all bit clocks outside the bits of a word.
- R8: Word-length code 0, 1, 2, 3 selects 16, 20, 24, 32 bits; samples are right aligned in the 32-bit inputs and bits above the word length are ignored.
- R9: The combination of format code 1 with length code 3, and format codes 5 to 7, keep `sdata` at 0.
- R10: `in_ready` is high exactly when the pending register is empty; an accepted pair moves into the holding register at the frame start (rising `lrclk` for codes 0, 1, 3, 4; falling `lrclk` for code 2), and a pair loaded mid-frame does not change the frame in progress.
- R11: At a frame start with no pending pair, `underrun` becomes 1 and the previous pair is sent again; the next frame start with a pending pair clears it.
- R12: `sdata` changes only in response to a falling bit-clock edge; moving `lrclk`, the configuration or loading samples while the bit clock is high leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External left-right clock or frame sync |
| fmt | input | 3 | Framing select: 0 left justified, 1 right justified, 2 I2S, 3 DSP early, 4 DSP late |
| wlen | input | 2 | Word length select: 16, 20, 24, 32 bits |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pending register empty |
| in_left | input | 32 | Left sample, right aligned |
| in_right | input | 32 | Right sample, right aligned |
| sdata | output | 1 | Serial data line |
| underrun | output | 1 | Last frame start found no new pair |

## Verification
A falling bit-clock edge is seen at the first system-clock edge after it appears, and the new data bit is on `sdata` right after that same edge; the bench holds the bit clock low for two system clocks and samples `sdata` just before raising it, so each captured bit belongs to exactly one bit period. The underrun flag updates at the same edge as the frame start, so the bench reads it only after the first bit of a frame has been clocked. `in_ready` falls one system clock after an accepted load, and the bench waits on it before offering the next pair. Captured phases are compared as whole vectors against words built from the requirements.

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int CNT_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk,
  input  logic        lrclk,
  input  logic [2:0]  fmt,
  input  logic [1:0]  wlen,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_left,
  input  logic [31:0] in_right,
  output logic        sdata,
  output logic        underrun
);
  localparam int CW = CNT_W + 1;
  localparam logic [2:0] F_LJ = 3'd0, F_RJ = 3'd1, F_I2S = 3'd2, F_DSPE = 3'd3, F_DSPL = 3'd4;

  logic             bclk_q, lr_q, full;
  logic [CNT_W-1:0] cnt, k_now;
  logic [CW-1:0]    len_hi, len_lo;
  logic [31:0]      hold_l, hold_r, pend_l, pend_r;

  wire fall     = bclk_q & ~bclk;
  wire lr_rise  = fall & lrclk & ~lr_q;
  wire lr_fall  = fall & ~lrclk & lr_q;
  wire is_dsp   = (fmt == F_DSPE) || (fmt == F_DSPL);
  wire restart  = is_dsp ? lr_rise : (lr_rise | lr_fall);
  wire frm_strt = (fmt == F_I2S) ? lr_fall : lr_rise;
  wire left_ph  = (fmt == F_I2S) ? ~lrclk : lrclk;
  wire take_new = frm_strt & full;

  wire [31:0] cur_l = take_new ? pend_l : hold_l;
  wire [31:0] cur_r = take_new ? pend_r : hold_r;

  assign in_ready = ~full;
  assign k_now = restart ? '0 : ((&cnt) ? cnt : cnt + CNT_W'(1));

  logic [CW-1:0] w, kx, ln, j, off, dly;
  logic          valid, take_r, nxt_bit;

  always_comb begin
    case (wlen)
      2'd0:    w = CW'(16);
      2'd1:    w = CW'(20);
      2'd2:    w = CW'(24);
      default: w = CW'(32);
    endcase
    kx     = {1'b0, k_now};
    ln     = lrclk ? len_hi : len_lo;
    dly    = (fmt == F_DSPL) ? CW'(1) : CW'(0);
    j      = kx - dly;
    valid  = 1'b0;
    off    = '0;
    take_r = ~left_ph;
    case (fmt)
      F_LJ: if (kx < w) begin
        valid = 1'b1;
        off   = w - CW'(1) - kx;
      end
      F_I2S: if (kx != '0 && kx <= w) begin
        valid = 1'b1;
        off   = w - kx;
      end
      F_RJ: if (wlen != 2'd3 && kx < ln && (ln - CW'(1) - kx) < w) begin
        valid = 1'b1;
        off   = ln - CW'(1) - kx;
      end
      F_DSPE, F_DSPL: if (kx >= dly) begin
        if (j < w) begin
          valid  = 1'b1;
          take_r = 1'b0;
          off    = w - CW'(1) - j;
        end else if (j < (w << 1)) begin
          valid  = 1'b1;
          take_r = 1'b1;
          off    = (w << 1) - CW'(1) - j;
        end
      end
      default: valid = 1'b0;
    endcase
    nxt_bit = valid & (take_r ? cur_r[off[4:0]] : cur_l[off[4:0]]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      lr_q     <= 1'b0;
      cnt      <= '0;
      len_hi   <= '0;
      len_lo   <= '0;
      full     <= 1'b0;
      hold_l   <= '0;
      hold_r   <= '0;
      pend_l   <= '0;
      pend_r   <= '0;
      sdata    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      bclk_q <= bclk;
      full   <= (full & ~frm_strt) | (in_valid & ~full);
      if (in_valid && !full) begin
        pend_l <= in_left;
        pend_r <= in_right;
      end
      if (take_new) begin
        hold_l <= pend_l;
        hold_r <= pend_r;
      end
      if (frm_strt) underrun <= ~full;
      if (fall) begin
        lr_q  <= lrclk;
        cnt   <= k_now;
        sdata <= nxt_bit;
        if (lr_rise) len_lo <= {1'b0, cnt} + CW'(1);
        if (lr_fall) len_hi <= {1'b0, cnt} + CW'(1);
      end
    end
  end
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bclk,
  input logic [2:0] fmt,
  input logic [1:0] wlen,
  input logic       in_valid,
  input logic       in_ready,
  input logic       sdata
);
  logic prev_b;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_b <= 1'b0;
    else        prev_b <= bclk;

  wire fell_now = prev_b & ~bclk;

  p_quiet_no_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !fell_now |=> $stable(sdata));

  p_rj32_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fell_now && fmt == 3'd1 && wlen == 2'd3) |=> !sdata);

  p_bad_fmt_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fell_now && fmt > 3'd4) |=> !sdata);

  p_accept_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .fmt(fmt), .wlen(wlen),
  .in_valid(in_valid), .in_ready(in_ready), .sdata(sdata)
);

// File: tb/aud_ser_tx_tb.sv
module aud_ser_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b1, lrclk = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic [1:0] wlen = 2'd0;
  logic in_valid = 1'b0;
  logic [31:0] in_left = '0, in_right = '0;
  logic in_ready, sdata, underrun;
  int n_chk = 0, n_bad = 0;
  logic [255:0] cap;

  aud_ser_tx u_dut (.clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .fmt(fmt), .wlen(wlen),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .sdata(sdata), .underrun(underrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual still running, expected finished");
    summary();
    $finish;
  end

  task automatic chk(input string rq, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic int wl(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : (c == 2'd2) ? 24 : 32;
  endfunction

  function automatic logic [255:0] ph_exp(input int f, input int w, input int n, input logic [31:0] d);
    logic [255:0] e = '0;
    for (int k = 0; k < n; k++) begin
      if (f == 0 && k < w)            e[k] = d[w-1-k];
      if (f == 2 && k >= 1 && k <= w) e[k] = d[w-k];
      if (f == 1 && k >= n - w)       e[k] = d[n-1-k];
    end
    return e;
  endfunction

  function automatic logic [255:0] dsp_exp(input int late, input int w, input int n,
                                           input logic [31:0] l, input logic [31:0] r);
    logic [255:0] e = '0;
    for (int k = 0; k < n; k++) begin
      int jj = k - late;
      if (jj >= 0 && jj < w)          e[k] = l[w-1-jj];
      else if (jj >= w && jj < 2 * w) e[k] = r[2*w-1-jj];
    end
    return e;
  endfunction

  task automatic tick(input logic lv, output logic b);
    @(negedge clk); bclk = 1'b0; lrclk = lv;
    repeat (2) @(negedge clk);
    b = sdata; bclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic play(input int n, input logic lv, input int ld_at,
                      input logic [31:0] l, input logic [31:0] r);
    logic b;
    cap = '0;
    for (int i = 0; i < n; i++) begin
      if (i == ld_at) load(l, r);
      tick(lv, b);
      cap[i] = b;
    end
  endtask

  task automatic t_reset();
    chk("R1 sdata", {255'b0, sdata}, 256'd0);
    chk("R1 underrun", {255'b0, underrun}, 256'd0);
    chk("R1 in_ready", {255'b0, in_ready}, 256'd1);
  endtask

  task automatic t_stereo(input logic [2:0] f, input logic [1:0] wc, input int half, input string rq,
                          input logic [31:0] al, input logic [31:0] ar,
                          input logic [31:0] bl, input logic [31:0] br);
    logic first = (f == 3'd2) ? 1'b0 : 1'b1;
    int w = wl(wc);
    fmt = f; wlen = wc;
    play(half, ~first, -1, '0, '0);
    load(al, ar);
    play(half, first, half / 2, bl, br);
    if (f != 3'd1) chk({rq, " R10 frame1 left"}, cap, ph_exp(f, w, half, al));
    play(half, ~first, -1, '0, '0);
    if (f != 3'd1) chk({rq, " R10 frame1 right"}, cap, ph_exp(f, w, half, ar));
    play(half, first, -1, '0, '0);
    chk({rq, " frame2 left"}, cap, ph_exp(f, w, half, bl));
    play(half, ~first, -1, '0, '0);
    chk({rq, " frame2 right"}, cap, ph_exp(f, w, half, br));
  endtask

  task automatic t_dsp(input logic late, input logic [1:0] wc, input int n, input string rq,
                       input logic [31:0] al, input logic [31:0] ar,
                       input logic [31:0] bl, input logic [31:0] br);
    logic b0;
    int w = wl(wc);
    fmt = late ? 3'd4 : 3'd3; wlen = wc;
    play(4, 1'b0, -1, '0, '0);
    load(al, ar);
    tick(1'b1, b0);
    play(n - 1, 1'b0, 3, bl, br);
    chk({rq, " R10 frame1"}, {cap[254:0], b0}, dsp_exp(int'(late), w, n, al, ar));
    tick(1'b1, b0);
    play(n - 1, 1'b0, -1, '0, '0);
    chk({rq, " frame2"}, {cap[254:0], b0}, dsp_exp(int'(late), w, n, bl, br));
  endtask

  task automatic t_underrun();
    fmt = 3'd0; wlen = 2'd0;
    play(18, 1'b0, -1, '0, '0);
    load(32'h0000_C3A5, 32'h0000_1E0F);
    play(18, 1'b1, -1, '0, '0);
    chk("R11 flag clear with data", {255'b0, underrun}, 256'd0);
    play(18, 1'b0, -1, '0, '0);
    play(18, 1'b1, -1, '0, '0);
    chk("R11 flag set on empty start", {255'b0, underrun}, 256'd1);
    chk("R11 left repeated", cap, ph_exp(0, 16, 18, 32'h0000_C3A5));
    play(18, 1'b0, -1, '0, '0);
    chk("R11 right repeated", cap, ph_exp(0, 16, 18, 32'h0000_1E0F));
    load(32'h0000_7A11, 32'h0000_0F0F);
    play(18, 1'b1, -1, '0, '0);
    chk("R11 flag cleared again", {255'b0, underrun}, 256'd0);
    chk("R11 new left after recovery", cap, ph_exp(0, 16, 18, 32'h0000_7A11));
    play(18, 1'b0, -1, '0, '0);
  endtask

  task automatic t_unsup();
    fmt = 3'd1; wlen = 2'd3;
    play(34, 1'b0, -1, '0, '0);
    load(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    play(34, 1'b1, -1, '0, '0);
    chk("R9 rj32 left silent", cap, 256'd0);
    play(34, 1'b0, -1, '0, '0);
    chk("R9 rj32 right silent", cap, 256'd0);
    fmt = 3'd5; wlen = 2'd0;
    play(20, 1'b1, -1, '0, '0);
    chk("R9 code5 high silent", cap, 256'd0);
    play(20, 1'b0, -1, '0, '0);
    chk("R9 code5 low silent", cap, 256'd0);
  endtask

  task automatic t_stable();
    logic b;
    fmt = 3'd0; wlen = 2'd0;
    play(4, 1'b0, -1, '0, '0);
    load(32'h0000_8001, 32'h0000_0000);
    tick(1'b1, b);
    lrclk = 1'b0; fmt = 3'd3;
    load(32'h0000_0000, 32'h0000_0000);
    repeat (6) @(negedge clk);
    chk("R12 held while bclk high", {255'b0, sdata}, {255'b0, b});
    chk("R12 MSB value", {255'b0, b}, 256'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_stereo(3'd0, 2'd0, 20, "R2 R8 lj16", 32'hABCD_1234, 32'h5555_9876, 32'h0F0F_8421, 32'h1111_F00D);
    t_stereo(3'd0, 2'd2, 24, "R2 R7 lj24", 32'h00A5_5A3C, 32'h00C0_FFEE, 32'h0081_0001, 32'h007E_D00B);
    t_stereo(3'd2, 2'd1, 22, "R3 i2s20", 32'h000F_5A5A, 32'h0008_0001, 32'h0007_1234, 32'h000C_CCCC);
    t_stereo(3'd1, 2'd2, 28, "R4 rj24", 32'h0080_0001, 32'h0012_3456, 32'h00F0_0F01, 32'h0055_AAAB);
    t_dsp(1'b0, 2'd0, 40, "R5 dsp early16", 32'h0000_9ABC, 32'h0000_4321, 32'h0000_8001, 32'h0000_F00F);
    t_dsp(1'b1, 2'd3, 70, "R6 dsp late32", 32'h8765_4321, 32'hDEAD_BEEF, 32'h8000_0001, 32'h1357_9BDF);
    t_underrun();
    t_unsup();
    t_stable();
    summary();
    $finish;
  end
endmodule